// File: doc/BRIEF.md
# Serial PROM Sequential Byte Fetcher

This block is a hardware master for a small serial EEPROM on a four-wire SPI-style link. It fetches a run of consecutive bytes, for example a stored station address, with no software in the loop. A one-cycle `start` pulse supplies a first address and a byte count. The block wakes the memory with a short preamble of two clock pulses while chip select is held inactive. It then reads one byte per transaction, and chip select is released between transactions.

Each transaction asserts chip select and shifts out a read instruction of 0x03 and an 8-bit address, both MSB first. It then clocks in eight data bits, also MSB first. Every finished byte appears on `byte_data` with a one-cycle `byte_valid` strobe. The address steps by one for the next transaction. After the last byte, `done` pulses for one cycle. A parameterised divider of the system clock sets the length of each serial clock half-period. Another parameter sets the idle gap between transactions.

Top module: `spi_prom_seq_reader`

## Requirements
- R1: `prom_cs_n` (active low) is high whenever no transaction is in progress: while idle, during the preamble and during the gaps between transactions.
- R2: Each transaction first shifts the read instruction 0x03 onto `prom_mosi`, MSB first, one bit per `prom_sclk` pulse. It then shifts the 8-bit byte address, MSB first. `prom_mosi` changes only while `prom_sclk` is low and is steady across each rising edge.
- R3: After the sixteen command bits, eight more clock pulses shift in data from `prom_miso`, MSB first. Each bit is sampled while `prom_sclk` is high. The assembled byte appears on `byte_data` with `byte_valid` high for exactly one cycle.
- R4: `prom_sclk` is low whenever `prom_cs_n` changes. Inside a transaction, every high phase lasts exactly HALF_DIV system clock cycles.
- R5: Between an accepted start and the first transaction, `prom_sclk` goes high, low, high, low while `prom_cs_n` stays high. That is exactly two rising edges.
- R6: Successive transactions use the addresses `start_addr`, `start_addr`+1, and so on, one transaction per byte. `prom_cs_n` stays high for GAP_HALVES*HALF_DIV-1 cycles between transactions.
- R7: The byte address wraps from 0xFF to 0x00.
- R8: A start with `byte_count` of zero raises `done` in the following cycle. It produces no chip-select activity and no `byte_valid`.
- R9: `busy` is high from the cycle after an accepted start until the cycle after the one-cycle `done` pulse. `done` follows the last byte.
- R10: A `start` pulse that arrives while `busy` is high is ignored. No extra transaction or byte results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a fetch |
| start_addr | input | ADDR_W | First byte address |
| byte_count | input | CNT_W | Number of bytes to fetch |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle pulse at the end of a fetch |
| byte_valid | output | 1 | One-cycle strobe marking a new byte |
| byte_data | output | DATA_W | Byte just read |
| prom_cs_n | output | 1 | Chip select to the memory, active low |
| prom_sclk | output | 1 | Serial clock to the memory |
| prom_mosi | output | 1 | Serial command and address out |
| prom_miso | input | 1 | Serial data in from the memory |

## Verification
A behavioural memory model answers each transaction from a computed content function, and a scoreboard predicts every byte and address. Single-byte fetches exercise the whole transaction once without any inter-transaction gap. Multi-byte runs add the gap timing and the address stepping. A run starting at 0xFE separates correct wrap-around from an address counter that saturates or widens. A count of zero, and a second start pulse issued in the middle of a run, separate correct start acceptance from designs that read spurious bytes or restart.

// File: rtl/spr_pkg.sv
package spr_pkg;
   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_WAKE,
      SQ_GAP,
      SQ_XFER,
      SQ_FIN
   } seq_state_t;

   // Three timed half-periods of wake-up; the fourth (low) merges into the first gap
   localparam int WAKE_HALVES = 3;
endpackage

// File: rtl/spr_half_tick.sv
module spr_half_tick #(
   parameter int HALF_DIV = 625
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;

   if (HALF_DIV < 2) begin : g_bad_div
      $error("spr_half_tick: HALF_DIV must be at least 2");
   end

   logic [CW-1:0] cnt;

   assign tick = run && (cnt == CW'(HALF_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run || tick)   cnt <= '0;
      else                     cnt <= cnt + 1'b1;
   end

   // R4: half-period ticks are never back to back
   a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/spr_frame_shifter.sv
module spr_frame_shifter #(
   parameter int TX_W   = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              load,
   input  logic [TX_W-1:0]   load_word,
   input  logic              miso,
   output logic              sclk,
   output logic              mosi,
   output logic              frame_done,
   output logic [DATA_W-1:0] rx_byte
);
   localparam int TOTAL = TX_W + DATA_W;
   localparam int BW    = $clog2(TOTAL);

   if (DATA_W < 2 || TX_W < 2) begin : g_bad_w
      $error("spr_frame_shifter: widths too small");
   end

   logic [TX_W-1:0] tx;
   logic [BW-1:0]   bidx;
   logic            high_ph;
   logic            active;

   assign mosi = tx[TX_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx         <= '0;
         bidx       <= '0;
         high_ph    <= 1'b0;
         active     <= 1'b0;
         sclk       <= 1'b0;
         frame_done <= 1'b0;
         rx_byte    <= '0;
      end else begin
         frame_done <= 1'b0;
         if (load) begin
            tx      <= load_word;
            bidx    <= '0;
            high_ph <= 1'b0;
            active  <= 1'b1;
            sclk    <= 1'b0;
         end else if (active && tick) begin
            if (!high_ph) begin
               high_ph <= 1'b1;
               sclk    <= 1'b1;
            end else begin
               if (bidx >= BW'(TX_W)) rx_byte <= {rx_byte[DATA_W-2:0], miso};
               high_ph <= 1'b0;
               sclk    <= 1'b0;
               if (bidx == BW'(TOTAL - 1)) begin
                  active     <= 1'b0;
                  frame_done <= 1'b1;
               end else begin
                  bidx <= bidx + 1'b1;
                  tx   <= {tx[TX_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   // R2: outgoing bit is steady through a high phase
   a_r2_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));
   // R3: a frame closes only after a high phase
   a_r3_close_after_high: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> $past(sclk));
endmodule

// File: rtl/spr_seq_ctrl.sv
module spr_seq_ctrl
   import spr_pkg::*;
#(
   parameter int          ADDR_W     = 8,
   parameter int          CNT_W      = 8,
   parameter int          DATA_W     = 8,
   parameter int          OP_W       = 8,
   parameter logic [7:0]  READ_OP    = 8'h03,
   parameter int          GAP_HALVES = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   tick,
   input  logic                   start,
   input  logic [ADDR_W-1:0]      start_addr,
   input  logic [CNT_W-1:0]       byte_count,
   input  logic                   frame_done,
   input  logic [DATA_W-1:0]      rx_byte,
   output logic                   load,
   output logic [OP_W+ADDR_W-1:0] load_word,
   output logic                   cs_n,
   output logic                   wake_sclk,
   output logic                   busy,
   output logic                   done,
   output logic                   byte_valid,
   output logic [DATA_W-1:0]      byte_data
);
   localparam int MAXH = (GAP_HALVES > WAKE_HALVES) ? GAP_HALVES : WAKE_HALVES;
   localparam int HW   = $clog2(MAXH + 1);

   if (GAP_HALVES < 1) begin : g_bad_gap
      $error("spr_seq_ctrl: GAP_HALVES must be at least 1");
   end

   seq_state_t        state;
   logic [ADDR_W-1:0] addr;
   logic [CNT_W-1:0]  remain;
   logic [HW-1:0]     hcnt;

   assign busy      = (state != SQ_IDLE);
   assign done      = (state == SQ_FIN);
   assign load      = (state == SQ_GAP) && tick && (hcnt == HW'(GAP_HALVES - 1));
   assign load_word = {READ_OP[OP_W-1:0], addr};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= SQ_IDLE;
         addr       <= '0;
         remain     <= '0;
         hcnt       <= '0;
         cs_n       <= 1'b1;
         wake_sclk  <= 1'b0;
         byte_valid <= 1'b0;
         byte_data  <= '0;
      end else begin
         byte_valid <= 1'b0;
         case (state)
            SQ_IDLE: begin
               cs_n      <= 1'b1;
               wake_sclk <= 1'b0;
               if (start) begin
                  addr   <= start_addr;
                  remain <= byte_count;
                  hcnt   <= '0;
                  if (byte_count == '0) begin
                     state <= SQ_FIN;
                  end else begin
                     state     <= SQ_WAKE;
                     wake_sclk <= 1'b1;
                  end
               end
            end
            SQ_WAKE: if (tick) begin
               if (hcnt == HW'(WAKE_HALVES - 1)) begin
                  state     <= SQ_GAP;
                  hcnt      <= '0;
                  wake_sclk <= 1'b0;
               end else begin
                  hcnt      <= hcnt + 1'b1;
                  wake_sclk <= ~wake_sclk;
               end
            end
            SQ_GAP: if (tick) begin
               if (load) begin
                  state <= SQ_XFER;
                  cs_n  <= 1'b0;
                  hcnt  <= '0;
               end else begin
                  hcnt <= hcnt + 1'b1;
               end
            end
            SQ_XFER: if (frame_done) begin
               byte_valid <= 1'b1;
               byte_data  <= rx_byte;
               addr       <= addr + 1'b1;
               remain     <= remain - 1'b1;
               cs_n       <= 1'b1;
               hcnt       <= '0;
               state      <= (remain == CNT_W'(1)) ? SQ_FIN : SQ_GAP;
            end
            SQ_FIN:  state <= SQ_IDLE;
            default: state <= SQ_IDLE;
         endcase
      end
   end

   a_r1_cs_high_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> cs_n);
   a_r8_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && byte_count == '0) |=> done);
   a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
   a_r6_valid_cs_released: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |-> cs_n);
endmodule

// File: rtl/spi_prom_seq_reader.sv
module spi_prom_seq_reader #(
   parameter int         ADDR_W     = 8,
   parameter int         CNT_W      = 8,
   parameter int         DATA_W     = 8,
   parameter int         HALF_DIV   = 625,
   parameter int         GAP_HALVES = 4,
   parameter logic [7:0] READ_OP    = 8'h03
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  byte_count,
   output logic              busy,
   output logic              done,
   output logic              byte_valid,
   output logic [DATA_W-1:0] byte_data,
   output logic              prom_cs_n,
   output logic              prom_sclk,
   output logic              prom_mosi,
   input  logic              prom_miso
);
   localparam int OP_W = 8;
   localparam int TX_W = OP_W + ADDR_W;

   logic              tick, load, frame_done, wake_sclk, shift_sclk;
   logic [TX_W-1:0]   load_word;
   logic [DATA_W-1:0] rx_byte;

   spr_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick));

   spr_seq_ctrl #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .OP_W(OP_W),
      .READ_OP(READ_OP), .GAP_HALVES(GAP_HALVES)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
      .start_addr(start_addr), .byte_count(byte_count),
      .frame_done(frame_done), .rx_byte(rx_byte), .load(load),
      .load_word(load_word), .cs_n(prom_cs_n), .wake_sclk(wake_sclk),
      .busy(busy), .done(done), .byte_valid(byte_valid), .byte_data(byte_data));

   spr_frame_shifter #(.TX_W(TX_W), .DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
      .load_word(load_word), .miso(prom_miso), .sclk(shift_sclk),
      .mosi(prom_mosi), .frame_done(frame_done), .rx_byte(rx_byte));

   assign prom_sclk = wake_sclk | shift_sclk;

   // R4: chip select only moves while the serial clock is low
   a_r4_cs_moves_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(prom_cs_n) || $rose(prom_cs_n)) |-> !prom_sclk);
   // R5: wake-up pulses never overlap an active chip select
   a_r5_wake_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
      wake_sclk |-> prom_cs_n);
endmodule

// File: tb/spi_prom_seq_reader_test.sv
module spi_prom_seq_reader_test;
   localparam int HALF = 3;
   localparam int GAP  = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] start_addr = '0;
   logic [7:0] byte_count = '0;
   logic       busy, done, byte_valid, prom_cs_n, prom_sclk, prom_mosi;
   logic [7:0] byte_data;
   logic       prom_miso = 1'b0;

   always #4 clk = ~clk;

   spi_prom_seq_reader #(.HALF_DIV(HALF), .GAP_HALVES(GAP)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .byte_count(byte_count), .busy(busy), .done(done),
      .byte_valid(byte_valid), .byte_data(byte_data), .prom_cs_n(prom_cs_n),
      .prom_sclk(prom_sclk), .prom_mosi(prom_mosi), .prom_miso(prom_miso));

   int n_vec = 0;
   int n_bad = 0;
   logic [7:0] exp_data[$];
   logic [7:0] exp_addr[$];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] rom(input logic [7:0] a);
      return (a * 8'd29) ^ 8'hC3;
   endfunction

   // Memory model
   int         rises = 0;
   int         frames = 0;
   int         pre_rises = 0;
   logic [15:0] cmd = '0;
   logic [7:0] cur_addr = '0;

   always @(negedge prom_cs_n) begin
      rises = 0;
      cmd = '0;
      frames++;
   end

   always @(posedge prom_sclk) begin
      if (!prom_cs_n) begin
         cmd = {cmd[14:0], prom_mosi};
         rises++;
         if (rises == 8) check(cmd[7:0] == 8'h03, "R2 opcode", cmd[7:0], 8'h03);
         if (rises == 16) begin
            cur_addr = cmd[7:0];
            if (exp_addr.size() == 0) check(1'b0, "R10 unexpected transaction", cur_addr, 0);
            else begin
               logic [7:0] ea;
               ea = exp_addr.pop_front();
               check(cur_addr == ea, "R6/R7 address", cur_addr, ea);
            end
         end
      end else if (busy) begin
         pre_rises++;
      end
   end

   always @(negedge prom_sclk) begin
      if (!prom_cs_n && rises >= 16 && rises < 24) begin
         logic [7:0] d;
         d = rom(cur_addr);
         prom_miso <= d[7 - (rises - 16)];
      end
   end

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && byte_valid) begin
         if (exp_data.size() == 0) check(1'b0, "R10 unexpected byte", byte_data, 0);
         else begin
            logic [7:0] ed;
            ed = exp_data.pop_front();
            check(byte_data == ed, "R3 byte data", byte_data, ed);
         end
      end
   end

   // Timing monitors
   int  hi_len = 0, hp_bad = 0, gap_len = 0, gap_bad = 0;
   bit  seen_frame = 1'b0;
   always @(negedge clk) begin
      if (!prom_cs_n) begin
         if (prom_sclk) hi_len++;
         else if (hi_len != 0) begin
            if (hi_len != HALF) hp_bad++;
            hi_len = 0;
         end
      end
      if (busy) begin
         if (prom_cs_n && seen_frame) gap_len++;
         else if (!prom_cs_n) begin
            if (gap_len != 0 && gap_len != GAP * HALF - 1) gap_bad++;
            gap_len = 0;
            seen_frame = 1'b1;
         end
      end
   end

   task automatic run(input logic [7:0] a, input logic [7:0] c, input bit poke);
      int waited;
      int busy_drop;
      for (int i = 0; i < c; i++) begin
         exp_addr.push_back(a + 8'(i));
         exp_data.push_back(rom(a + 8'(i)));
      end
      frames = 0; pre_rises = 0; hp_bad = 0; gap_bad = 0; gap_len = 0;
      seen_frame = 1'b0; waited = 0; busy_drop = 0;
      @(negedge clk);
      start = 1'b1; start_addr = a; byte_count = c;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R9 busy after start", busy, 1);
      if (poke) begin
         repeat (200) @(negedge clk);
         start = 1'b1; start_addr = 8'h00; byte_count = 8'd5;  // R10
         @(negedge clk);
         start = 1'b0;
      end
      while (!done && waited < 20000) begin
         @(negedge clk);
         waited++;
         if (!busy) busy_drop++;
      end
      if (c == 0) check(waited == 0, "R8 immediate done", waited, 0);
      @(negedge clk);
      check(!done && !busy, "R9 done one cycle then idle", {done, busy}, 0);
      repeat (20) @(negedge clk);
      check(busy_drop == 0, "R9 busy held", busy_drop, 0);
      check(exp_data.size() == 0, "R3 all bytes delivered", exp_data.size(), 0);
      check(frames == c, "R6 one transaction per byte", frames, c);
      check(pre_rises == ((c != 0) ? 2 : 0), "R5 preamble pulses", pre_rises, (c != 0) ? 2 : 0);
      check(hp_bad == 0, "R4 high phase length", hp_bad, 0);
      check(gap_bad == 0, "R6 gap length", gap_bad, 0);
      check(prom_cs_n == 1'b1, "R1 cs released after run", prom_cs_n, 1);
      exp_addr.delete();
      exp_data.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(prom_cs_n == 1'b1, "R1 cs in reset", prom_cs_n, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(prom_cs_n == 1'b1 && !prom_sclk && !busy && !done && !byte_valid,
            "R1 reset state", {prom_cs_n, prom_sclk, busy, done, byte_valid}, 5'b10000);
      run(8'h10, 8'd1, 1'b0);   // single byte, no gap
      run(8'h3C, 8'd4, 1'b0);   // R6 consecutive addresses
      run(8'hFE, 8'd3, 1'b0);   // R7 wrap FF -> 00
      run(8'h55, 8'd0, 1'b0);   // R8 zero count
      run(8'h80, 8'd2, 1'b1);   // R10 start while busy
      run(8'hA5, 8'd2, 1'b0);   // R2 alternating address bits
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL R9 watchdog: actual 0x0 expected 0x1 (done)");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule